// File: doc/BRIEF.md
# Interrupt Trigger Store Generator

This block turns interrupt events from a host-bridge interrupt source into memory stores aimed at an interrupt controller. Each accepted event produces exactly one single-beat 64-bit write. The write's address and data are built from the event's source number, its "state already checked" flag and three configuration words: a target address, a base index and a control word.

There are two ways to build the write. In page-addressed mode the source number is folded into the address. The write lands on the management page, which is the upper page of a per-source pair of pages, and the data is zero. In port mode every write goes to the same target address, and the source number, offset by the base index, travels in the data. Stores are presented in big-endian byte order. A write response that reports an error is logged: a sticky flag is set, a saturating counter advances, and the failing address is kept. The event is then dropped without a retry.

The block handles one event at a time. The event side is released only when the write response for the previous event has returned.

Top module: `irq_trig_store`

## Requirements
- R1: Bit 0 of `cfg_ctl` selects the mode at event acceptance: 1 selects page-addressed mode, 0 selects port mode.
- R2: In page-addressed mode, bit 0 of `cfg_notify_addr` selects the page shift: 16 when set, 12 when clear.
- R3: In page-addressed mode the write address is `cfg_notify_addr` with bit 0 cleared, OR (source × 2^(shift+1)), OR 2^shift.
- R4: In page-addressed mode a set checked flag also ORs the inject offset 0x800 into the address. A clear flag leaves it out.
- R5: In page-addressed mode the store value is all zeros.
- R6: In port mode the write address is `cfg_notify_addr` unchanged, including bit 0, and the store value is the zero-extended `cfg_base_idx` OR the source number.
- R7: In port mode a set checked flag also sets bit 31 of the store value. A clear flag leaves bit 31 to the base and source alone.
- R8: The store value is sent big-endian: `wr_data[63:56]` carries value bits 7:0, and so on, with `wr_data[7:0]` carrying value bits 63:56.
- R9: The states are IDLE, REQ and WAIT. IDLE goes to REQ when an event is accepted. REQ goes to WAIT when `wr_ready` is high. WAIT goes back to IDLE when `rsp_valid` is high. `ev_ready` is high only in IDLE, and `wr_valid` is high only in REQ. The request appears one cycle after acceptance and holds address and data steady until `wr_ready`.
- R10: Mode, addresses, index, source and flag are captured at acceptance. Configuration changes made afterwards do not alter the pending write.
- R11: A response with `rsp_err` set does the following: it sets `err_sticky`, which is held until reset; it increments `err_count`, which saturates at its maximum; and it loads the write address into `err_addr`. The block then returns to IDLE with no second write. A response without error changes none of the three.
- R12: After reset `ev_ready` is 1, `wr_valid` is 0, and `err_sticky`, `err_count` and `err_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Interrupt event offered |
| ev_ready | output | 1 | Block can take an event (IDLE) |
| ev_src | input | SRC_W | Source number of the event |
| ev_chk | input | 1 | State bits already checked at the source |
| cfg_notify_addr | input | 64 | Target address; bit 0 selects the large page |
| cfg_base_idx | input | IDX_W | Base index added into port-mode data |
| cfg_ctl | input | CTL_W | Control word; bit 0 selects the mode |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request taken |
| wr_addr | output | 64 | Write address |
| wr_data | output | 64 | Store value in big-endian byte lanes |
| rsp_valid | input | 1 | Write response present |
| rsp_err | input | 1 | Write response reports a failure |
| err_sticky | output | 1 | At least one failed write since reset |
| err_count | output | CNT_W | Saturating count of failed writes |
| err_addr | output | 64 | Address of the latest failed write |

## Verification
An event offered before a clock edge in IDLE shows up as `wr_valid` with its final address and data right after that edge. A `wr_ready` seen at an edge moves the block into WAIT at that edge. A response at an edge updates the error outputs and raises `ev_ready` at that same edge. The bench changes inputs on falling edges and reads outputs on the next falling edge, so each result is sampled exactly one edge after its cause. During deliberate `wr_ready` stalls it samples at every falling edge to confirm that the request holds.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

    localparam int STORE_W = 64;
    localparam int STORE_BYTES = STORE_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } trig_state_e;

    typedef struct packed {
        logic [STORE_W-1:0] addr;
        logic [STORE_W-1:0] value;
    } trig_cmd_t;

endpackage

// File: rtl/irq_trig_compose.sv
module irq_trig_compose
    import irq_trig_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int IDX_W = 32,
    parameter int CTL_W = 32,
    parameter int MODE_BIT = 0,
    parameter int PG_BIT = 0,
    parameter int CHK_BIT = 31,
    parameter int SHIFT_SMALL = 12,
    parameter int SHIFT_LARGE = 16,
    parameter logic [STORE_W-1:0] INJECT_OFS = 64'h800
) (
    input  logic [SRC_W-1:0]   src,
    input  logic               chk,
    input  logic [STORE_W-1:0] notify_addr,
    input  logic [IDX_W-1:0]   base_idx,
    input  logic [CTL_W-1:0]   ctl,
    output trig_cmd_t          cmd
);

    localparam logic [STORE_W-1:0] PG_MASK   = STORE_W'(1) << PG_BIT;
    localparam logic [STORE_W-1:0] CHK_FLAG  = STORE_W'(1) << CHK_BIT;
    localparam logic [STORE_W-1:0] MGMT_SM   = STORE_W'(1) << SHIFT_SMALL;
    localparam logic [STORE_W-1:0] MGMT_LG   = STORE_W'(1) << SHIFT_LARGE;

    logic               page_mode;
    logic               large_page;
    logic [STORE_W-1:0] src_wide;
    logic [STORE_W-1:0] pair_ofs;
    logic [STORE_W-1:0] page_addr;
    logic [STORE_W-1:0] port_value;

    always_comb begin
        page_mode  = ctl[MODE_BIT];
        large_page = notify_addr[PG_BIT];
        src_wide   = STORE_W'(src);

        // Each source owns a pair of pages; the upper one is the management page.
        if (large_page) begin
            pair_ofs = (src_wide << (SHIFT_LARGE + 1)) | MGMT_LG;
        end else begin
            pair_ofs = (src_wide << (SHIFT_SMALL + 1)) | MGMT_SM;
        end

        page_addr = (notify_addr & ~PG_MASK) | pair_ofs;
        if (chk) begin
            page_addr = page_addr | INJECT_OFS;
        end

        port_value = STORE_W'(base_idx) | src_wide;
        if (chk) begin
            port_value = port_value | CHK_FLAG;
        end

        if (page_mode) begin
            cmd.addr  = page_addr;
            cmd.value = '0;
        end else begin
            cmd.addr  = notify_addr;
            cmd.value = port_value;
        end
    end

endmodule

// File: rtl/irq_trig_bswap.sv
module irq_trig_bswap
    import irq_trig_pkg::*;
#(
    parameter int NBYTES = STORE_BYTES
) (
    input  logic [NBYTES*8-1:0] din,
    output logic [NBYTES*8-1:0] dout
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign dout[(NBYTES-1-b)*8 +: 8] = din[b*8 +: 8];
    end

endmodule

// File: rtl/irq_trig_errlog.sv
module irq_trig_errlog
    import irq_trig_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsp_fire,
    input  logic               rsp_err,
    input  logic [STORE_W-1:0] cur_addr,
    output logic               sticky,
    output logic [CNT_W-1:0]   count,
    output logic [STORE_W-1:0] fail_addr
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic fail_hit;

    assign fail_hit = rsp_fire && rsp_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky    <= 1'b0;
            count     <= '0;
            fail_addr <= '0;
        end else if (fail_hit) begin
            sticky    <= 1'b1;
            fail_addr <= cur_addr;
            if (count != CNT_MAX) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_trig_store.sv
module irq_trig_store
    import irq_trig_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int IDX_W = 32,
    parameter int CTL_W = 32,
    parameter int CNT_W = 8,
    parameter int MODE_BIT = 0,
    parameter int PG_BIT = 0,
    parameter int CHK_BIT = 31,
    parameter logic [63:0] INJECT_OFS = 64'h800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    output logic             ev_ready,
    input  logic [SRC_W-1:0] ev_src,
    input  logic             ev_chk,
    input  logic [63:0]      cfg_notify_addr,
    input  logic [IDX_W-1:0] cfg_base_idx,
    input  logic [CTL_W-1:0] cfg_ctl,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [63:0]      wr_addr,
    output logic [63:0]      wr_data,
    input  logic             rsp_valid,
    input  logic             rsp_err,
    output logic             err_sticky,
    output logic [CNT_W-1:0] err_count,
    output logic [63:0]      err_addr
);

    trig_state_e state_q, state_d;
    trig_cmd_t   cmd_new, cmd_q;
    logic        accept;
    logic        rsp_fire;

    irq_trig_compose #(
        .SRC_W(SRC_W), .IDX_W(IDX_W), .CTL_W(CTL_W),
        .MODE_BIT(MODE_BIT), .PG_BIT(PG_BIT), .CHK_BIT(CHK_BIT),
        .SHIFT_SMALL(12), .SHIFT_LARGE(16), .INJECT_OFS(INJECT_OFS)
    ) u_compose (
        .src(ev_src),
        .chk(ev_chk),
        .notify_addr(cfg_notify_addr),
        .base_idx(cfg_base_idx),
        .ctl(cfg_ctl),
        .cmd(cmd_new)
    );

    assign accept   = (state_q == ST_IDLE) && ev_valid;
    assign rsp_fire = (state_q == ST_WAIT) && rsp_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_new;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ev_valid)  state_d = ST_REQ;
            ST_REQ:  if (wr_ready)  state_d = ST_WAIT;
            ST_WAIT: if (rsp_valid) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ev_ready = 1'b0;
        wr_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ev_ready = 1'b1;
            ST_REQ:  wr_valid = 1'b1;
            ST_WAIT: ;
            default: ;
        endcase
    end

    assign wr_addr = cmd_q.addr;

    irq_trig_bswap #(.NBYTES(STORE_BYTES)) u_bswap (
        .din(cmd_q.value),
        .dout(wr_data)
    );

    irq_trig_errlog #(.CNT_W(CNT_W)) u_errlog (
        .clk(clk),
        .rst_n(rst_n),
        .rsp_fire(rsp_fire),
        .rsp_err(rsp_err),
        .cur_addr(cmd_q.addr),
        .sticky(err_sticky),
        .count(err_count),
        .fail_addr(err_addr)
    );

endmodule

// File: rtl/irq_trig_store_chk.sv
module irq_trig_store_chk #(
    parameter int SRC_W = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_valid,
    input logic             ev_ready,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [63:0]      wr_addr,
    input logic [63:0]      wr_data,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic             err_sticky,
    input logic [CNT_W-1:0] err_count,
    input logic [63:0]      err_addr
);

    logic waiting;
    assign waiting = !ev_ready && !wr_valid;

    // R9: never offering an event slot while a request is out
    a_r9_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_ready && wr_valid));

    // R9: acceptance leads to a request on the next cycle
    a_r9_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> (wr_valid && !ev_ready));

    // R9, R10: a stalled request keeps its address and data
    a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R11: failed response records the address and sets the flag
    a_r11_err_log: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rsp_valid && rsp_err) |=>
            (err_sticky && err_addr == $past(wr_addr) && ev_ready && !wr_valid));

    // R11: error count steps or stays saturated
    a_r11_err_count: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rsp_valid && rsp_err) |=>
            ((err_count == $past(err_count) + 1'b1) || (&$past(err_count))));

    // R11: a clean response leaves the count alone
    a_r11_ok_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rsp_valid && !rsp_err) |=> $stable(err_count));

    // R11: the flag is held once set
    a_r11_sticky_held: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

endmodule

bind irq_trig_store irq_trig_store_chk #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .ev_valid(ev_valid),
    .ev_ready(ev_ready),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rsp_valid(rsp_valid),
    .rsp_err(rsp_err),
    .err_sticky(err_sticky),
    .err_count(err_count),
    .err_addr(err_addr)
);

// File: tb/sim_irq_trig_store.sv
`timescale 1ns/1ps
module sim_irq_trig_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [15:0] ev_src = '0;
    logic        ev_chk = 1'b0;
    logic [63:0] cfg_notify_addr = '0;
    logic [31:0] cfg_base_idx = '0;
    logic [31:0] cfg_ctl = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [63:0] wr_addr;
    logic [63:0] wr_data;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic        err_sticky;
    logic [7:0]  err_count;
    logic [63:0] err_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_trig_store u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_src(ev_src), .ev_chk(ev_chk),
        .cfg_notify_addr(cfg_notify_addr), .cfg_base_idx(cfg_base_idx), .cfg_ctl(cfg_ctl),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .err_sticky(err_sticky), .err_count(err_count), .err_addr(err_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one event through; compare request against expected address/lanes.
    task automatic run_event(input string req, input logic [15:0] src, input logic chk,
                             input logic [63:0] exp_addr, input logic [63:0] exp_lanes,
                             input int stall, input bit fail, input bit disturb);
        @(negedge clk);
        ev_src = src; ev_chk = chk; ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0; ev_src = 16'h1234; ev_chk = ~chk;
        check("R9 request after accept", {62'd0, wr_valid, ev_ready}, 64'd2);
        check({req, " address"}, wr_addr, exp_addr);
        check({req, " data R8"}, wr_data, exp_lanes);
        if (disturb) begin
            cfg_ctl = ~cfg_ctl; cfg_notify_addr = 64'hFFFF_0000_0000_0001;
            cfg_base_idx = 32'hDEAD_BEEF;
        end
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check("R9 held during stall", {63'd0, wr_valid}, 64'd1);
            check("R10 address held", wr_addr, exp_addr);
            check("R10 data held", wr_data, exp_lanes);
        end
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        check("R9 WAIT state", {62'd0, wr_valid, ev_ready}, 64'd0);
        rsp_valid = 1'b1; rsp_err = fail;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
        check("R9 back to IDLE", {62'd0, wr_valid, ev_ready}, 64'd1);
    endtask

    task automatic t_reset();
        check("R12 ev_ready", {63'd0, ev_ready}, 64'd1);
        check("R12 wr_valid", {63'd0, wr_valid}, 64'd0);
        check("R12 err_sticky", {63'd0, err_sticky}, 64'd0);
        check("R12 err_count", {56'd0, err_count}, 64'd0);
        check("R12 err_addr", err_addr, 64'd0);
    endtask

    task automatic t_page_small();
        cfg_ctl = 32'h1; cfg_notify_addr = 64'h0000_0060_0000_0000;
        run_event("R1 R3 R5 4K src5", 16'd5, 1'b0, 64'h0000_0060_0000_B000, 64'd0, 1, 0, 0);
        run_event("R4 R3 4K srcmax chk", 16'hFFFF, 1'b1, 64'h0000_0060_1FFF_F800, 64'd0, 0, 0, 0);
    endtask

    task automatic t_page_large();
        cfg_ctl = 32'h1; cfg_notify_addr = 64'h0000_0060_0000_0001;
        run_event("R2 R4 64K src0 chk", 16'd0, 1'b1, 64'h0000_0060_0001_0800, 64'd0, 0, 0, 0);
        run_event("R2 R3 64K srcmax", 16'hFFFF, 1'b0, 64'h0000_0061_FFFF_0000, 64'd0, 2, 0, 0);
    endtask

    task automatic t_port();
        cfg_ctl = 32'h0; cfg_notify_addr = 64'h0000_0060_0300_0001;
        cfg_base_idx = 32'h0000_1000;
        run_event("R1 R6 port src42", 16'h0042, 1'b0, 64'h0000_0060_0300_0001,
                  64'h4210_0000_0000_0000, 0, 0, 0);
        cfg_base_idx = 32'h0002_0000;
        run_event("R7 R8 port srcmax chk", 16'hFFFF, 1'b1, 64'h0000_0060_0300_0001,
                  64'hFFFF_0280_0000_0000, 0, 0, 0);
        cfg_base_idx = 32'h0000_0000;
        run_event("R6 R7 port src0", 16'd0, 1'b0, 64'h0000_0060_0300_0001, 64'd0, 0, 0, 0);
    endtask

    task automatic t_capture();
        cfg_ctl = 32'h1; cfg_notify_addr = 64'h0000_0060_0000_0000;
        run_event("R10 capture", 16'd5, 1'b0, 64'h0000_0060_0000_B000, 64'd0, 3, 0, 1);
    endtask

    task automatic t_error();
        cfg_ctl = 32'h1; cfg_notify_addr = 64'h0000_0060_0000_0000;
        check("R11 no error yet", {63'd0, err_sticky}, 64'd0);
        run_event("R11 failing write", 16'd5, 1'b1, 64'h0000_0060_0000_B800, 64'd0, 0, 1, 0);
        check("R11 sticky set", {63'd0, err_sticky}, 64'd1);
        check("R11 count", {56'd0, err_count}, 64'd1);
        check("R11 failing address", err_addr, 64'h0000_0060_0000_B800);
        repeat (3) begin
            @(negedge clk);
            check("R11 no retry", {62'd0, wr_valid, ev_ready}, 64'd1);
        end
        run_event("R11 clean write", 16'd7, 1'b0, 64'h0000_0060_0000_F000, 64'd0, 0, 0, 0);
        check("R11 count unchanged", {56'd0, err_count}, 64'd1);
        check("R11 sticky held", {63'd0, err_sticky}, 64'd1);
        check("R11 address kept", err_addr, 64'h0000_0060_0000_B800);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page_small();
        t_page_large();
        t_port();
        t_capture();
        t_error();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule